// File: doc/BRIEF.md
# Quadrature encoder input conditioner

This block sits between the four raw encoder pins (phase A, phase B, index and home) and a quadrature decoder. It first brings each pin into the module clock domain through a short synchronizer chain. It then applies a separate invert control to each line and can exchange the roles of phase A and phase B. Last, it can pass all four lines through a shared glitch filter whose sample rate is the module clock divided by a selectable power of two.

The conditioned levels drive the decoder-facing outputs. The same levels are also presented as a four-bit read-only status vector, so software can see what the decoder sees. The whole block runs on one clock. The divider produces a one-cycle sample-enable pulse and never a derived clock. Configuration arrives as plain input signals. The decoder and the position counter lie outside this block.

Top module: `qenc_cond`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released with all controls at 0, every decoder output and every status bit is 0.
- R2: With swap off and the filter off, each line's output equals its synchronized raw pin XOR that line's invert control.
- R3: Invert controls act on the physical pins. With swap at 1 and the filter off, `dec_a` carries the conditioned physical B pin (`raw_b ^ inv_b`), and `dec_b` carries the conditioned physical A pin (`raw_a ^ inv_a`).
- R4: The status vector holds `stat_lvl[0]`=`dec_a`, `stat_lvl[1]`=`dec_b`, `stat_lvl[2]`=`dec_idx` and `stat_lvl[3]`=`dec_home`. A and B are therefore shown after both inversion and swap, and index and home after inversion.
- R5: With the filter off, a change on a raw pin reaches its output after exactly two clock edges: the output still holds the old value after the first edge and holds the new one after the second.
- R6: Divide select code s (0 to 7) gives one sample tick every 2^s clock cycles, so ratios run from 1:1 up to 1:128.
- R7: With the filter on, an output takes a new level only after three consecutive sample ticks have all seen that level. Let P be the tick period. A pulse lasting 2P clock cycles never reaches the output. A level held steady reaches the output no sooner than 2P+3 edges and no later than 3P+2 edges after the pin changes.
- R8: A change of divide select restarts the divider from zero, and no tick occurs on the edge where the change is seen. If the new code is s, the ticks land 2^s, 2·2^s, … edges after that edge. An input that is already synchronized and pending therefore reaches the output exactly 3·2^s edges after the change.
- R9: While the filter is off, its state follows the conditioned input. Turning the filter on while the inputs are steady leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_a | input | 1 | Phase A pin |
| raw_b | input | 1 | Phase B pin |
| raw_idx | input | 1 | Index pin |
| raw_home | input | 1 | Home pin |
| inv_a | input | 1 | Invert the physical A pin when 1 |
| inv_b | input | 1 | Invert the physical B pin when 1 |
| inv_idx | input | 1 | Invert the index pin when 1 |
| inv_home | input | 1 | Invert the home pin when 1 |
| swap_ab | input | 1 | Exchange the roles of A and B when 1 |
| filt_en | input | 1 | Route the lines through the glitch filter when 1 |
| div_sel | input | DIV_SEL_W | Filter sample ratio 1:2^div_sel |
| dec_a | output | 1 | Conditioned phase A to the decoder |
| dec_b | output | 1 | Conditioned phase B to the decoder |
| dec_idx | output | 1 | Conditioned index to the decoder |
| dec_home | output | 1 | Conditioned home to the decoder |
| stat_lvl | output | 4 | Read-only conditioned levels {home, index, B, A} |

## Verification
The bench sweeps every raw pattern against every invert and swap setting. A design that inverted after the swap, rather than before it, would attach the wrong invert bit to `dec_a` and `dec_b`, and the status bits would diverge from the outputs as well. At every divide ratio the bench sends a pulse of 2P cycles and then a held level, which catches a filter that accepts after two ticks or that waits for a fourth. It also pins down the exact edge at which a pending level appears after a divide-select change, so a divider that kept its old phase, or ticked on the change edge, would flip the output at the wrong edge. Bypass latency is measured edge by edge, and the filter is switched on over steady inputs to make sure that step does not glitch the outputs.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
    localparam int unsigned LINES   = 4;
    localparam int unsigned LN_A    = 0;
    localparam int unsigned LN_B    = 1;
    localparam int unsigned LN_IDX  = 2;
    localparam int unsigned LN_HOME = 3;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int unsigned LINES  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    logic [STAGES-1:0][LINES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/qenc_div.sv
module qenc_div #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int unsigned CNT_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [CNT_W:0]   one_sh;
    logic [CNT_W-1:0] limit;
    logic             restart;

    always_comb begin
        one_sh  = (CNT_W+1)'(1) << sel;
        limit   = one_sh[CNT_W-1:0] - CNT_W'(1);
        restart = (st_q.sel != sel);
        tick    = !restart && (st_q.cnt == limit);
        st_d.sel = sel;
        if (restart || tick) st_d.cnt = '0;
        else                 st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    tick_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.cnt == '0));
    // R8
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sel != sel) |=> (st_q.cnt == '0) && (st_q.sel == $past(sel)));
endmodule

// File: rtl/qenc_filt.sv
module qenc_filt #(
    parameter int unsigned LINES      = 4,
    parameter int unsigned HOLD_TICKS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    localparam int unsigned CW = $clog2(HOLD_TICKS + 1);

    typedef struct packed {
        logic [LINES-1:0]         lvl;
        logic [LINES-1:0][CW-1:0] cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < LINES; i++) begin
            if (!en) begin
                st_d.lvl[i] = din[i];
                st_d.cnt[i] = '0;
            end else if (tick) begin
                if (din[i] != st_q.lvl[i]) begin
                    if (st_q.cnt[i] == CW'(HOLD_TICKS - 1)) begin
                        st_d.lvl[i] = din[i];
                        st_d.cnt[i] = '0;
                    end else begin
                        st_d.cnt[i] = st_q.cnt[i] + CW'(1);
                    end
                end else begin
                    st_d.cnt[i] = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.lvl;

    // R7
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(st_q.lvl));

    for (genvar g = 0; g < LINES; g++) begin : g_line_chk
        // R7
        match_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en && tick && (din[g] == st_q.lvl[g])) |=> (st_q.lvl[g] == $past(st_q.lvl[g])));
        // R9
        bypass_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> (st_q.lvl[g] == $past(din[g])));
    end
endmodule

// File: rtl/qenc_cond.sv
module qenc_cond #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HOLD_TICKS  = 3,
    parameter int unsigned DIV_SEL_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 raw_a,
    input  logic                 raw_b,
    input  logic                 raw_idx,
    input  logic                 raw_home,
    input  logic                 inv_a,
    input  logic                 inv_b,
    input  logic                 inv_idx,
    input  logic                 inv_home,
    input  logic                 swap_ab,
    input  logic                 filt_en,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 dec_a,
    output logic                 dec_b,
    output logic                 dec_idx,
    output logic                 dec_home,
    output logic [3:0]           stat_lvl
);
    import qenc_pkg::*;

    logic [LINES-1:0] raw_vec, inv_vec, syn_vec, pol_vec, cond_vec, filt_vec, out_vec;
    logic             tick;
    logic [1:0]       age_d, age_q;

    assign raw_vec = {raw_home, raw_idx, raw_b, raw_a};
    assign inv_vec = {inv_home, inv_idx, inv_b, inv_a};

    qenc_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw_vec), .dout(syn_vec)
    );

    qenc_div #(.SEL_W(DIV_SEL_W)) u_div (
        .clk(clk), .rst_n(rst_n), .sel(div_sel), .tick(tick)
    );

    always_comb begin
        pol_vec  = syn_vec ^ inv_vec;
        cond_vec = pol_vec;
        if (swap_ab) begin
            cond_vec[LN_A] = pol_vec[LN_B];
            cond_vec[LN_B] = pol_vec[LN_A];
        end
    end

    qenc_filt #(.LINES(LINES), .HOLD_TICKS(HOLD_TICKS)) u_filt (
        .clk(clk), .rst_n(rst_n), .en(filt_en), .tick(tick),
        .din(cond_vec), .dout(filt_vec)
    );

    assign out_vec  = filt_en ? filt_vec : cond_vec;
    assign dec_a    = out_vec[LN_A];
    assign dec_b    = out_vec[LN_B];
    assign dec_idx  = out_vec[LN_IDX];
    assign dec_home = out_vec[LN_HOME];
    assign stat_lvl = out_vec;

    always_comb begin
        age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    // R5
    idx_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!filt_en && age_q == 2'd3) |-> (dec_idx == ($past(raw_idx, 2) ^ inv_idx)));
    // R5
    home_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!filt_en && age_q == 2'd3) |-> (dec_home == ($past(raw_home, 2) ^ inv_home)));
    // R3
    swap_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!filt_en && swap_ab && age_q == 2'd3) |-> (dec_a == ($past(raw_b, 2) ^ inv_b)));
endmodule

// File: tb/qenc_cond_bench.sv
`timescale 1ns/1ps
module qenc_cond_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] raw = '0;
    logic [3:0] inv = '0;
    logic swap = 1'b0, fen = 1'b0;
    logic [2:0] sel = '0;
    logic da, db, di, dh;
    logic [3:0] stat;
    int errors = 0, checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    qenc_cond u_qenc_cond (
        .clk(clk), .rst_n(rst_n),
        .raw_a(raw[0]), .raw_b(raw[1]), .raw_idx(raw[2]), .raw_home(raw[3]),
        .inv_a(inv[0]), .inv_b(inv[1]), .inv_idx(inv[2]), .inv_home(inv[3]),
        .swap_ab(swap), .filt_en(fen), .div_sel(sel),
        .dec_a(da), .dec_b(db), .dec_idx(di), .dec_home(dh), .stat_lvl(stat)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] expect_lvl(input logic [3:0] r, input logic [3:0] iv, input logic sw);
        logic [3:0] p;
        p = r ^ iv;
        if (sw) return {p[3], p[2], p[0], p[1]};
        return p;
    endfunction

    initial begin
        logic [3:0] e;
        int p;
        bit seen;
        // R1 during reset
        raw = 4'hF;
        step(3);
        chk("R1 in reset", {stat, dh, di, db, da}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {stat, dh, di, db, da}, 8'h00);
        step(2);
        raw = '0;
        step(3);

        // R2 R3 R4 sweep, bypass
        for (int c = 0; c < 32; c++) begin
            inv = c[3:0];
            swap = c[4];
            for (int r = 0; r < 16; r++) begin
                raw = r[3:0];
                step(2);
                e = expect_lvl(raw, inv, swap);
                if (swap) chk("R3 R4 swap sweep", {stat, dh, di, db, da}, {e, e});
                else      chk("R2 R4 invert sweep", {stat, dh, di, db, da}, {e, e});
            end
        end
        inv = '0; swap = 0; raw = '0;
        step(3);

        // R5 bypass latency
        for (int k = 0; k < 4; k++) begin
            raw = 4'h1 << k;
            step(1);
            chk("R5 one edge old", {4'h0, stat}, 8'h00);
            step(1);
            chk("R5 two edges new", {4'h0, stat}, {4'h0, 4'h1 << k});
            raw = '0;
            step(3);
        end

        // R9 enable filter over steady inputs
        raw = 4'hA;
        step(4);
        fen = 1'b1;
        step(1);
        chk("R9 enable no glitch", {4'h0, stat}, 8'h0A);
        step(3);
        chk("R9 steady after enable", {4'h0, stat}, 8'h0A);
        fen = 1'b0; raw = '0;
        step(4);
        fen = 1'b1;

        // R6 R7 per ratio: reject 2P pulse, accept held level within bounds
        for (int s = 0; s < 8; s++) begin
            sel = s[2:0];
            p = 1 << s;
            step(4 * p + 4);
            raw = 4'h1;
            seen = 0;
            for (int t = 0; t < 2 * p; t++) begin
                step(1);
                if (da) seen = 1;
            end
            raw = '0;
            for (int t = 0; t < 3 * p + 4; t++) begin
                step(1);
                if (da) seen = 1;
            end
            chk($sformatf("R7 pulse 2P rejected s=%0d", s), {7'd0, seen}, 8'd0);
            raw = 4'h1;
            step(2 * p + 2);
            chk($sformatf("R7 not before 2P+3 s=%0d", s), {7'd0, da}, 8'd0);
            step(p + 2);
            chk($sformatf("R6 R7 accepted by 3P+4 s=%0d", s), {7'd0, da}, 8'd1);
            raw = '0;
            step(3 * p + 4);
            chk($sformatf("R7 release s=%0d", s), {7'd0, da}, 8'd0);
        end

        // R8 exact timing after divider restart
        for (int s = 0; s < 6; s++) begin
            p = 1 << s;
            sel = 3'd6;
            step(1);
            sel = 3'd7;
            step(1);
            raw = 4'h1;
            step(5);
            sel = s[2:0];
            step(3 * p);
            chk($sformatf("R8 old at 3P-1 s=%0d", s), {7'd0, da}, 8'd0);
            step(1);
            chk($sformatf("R8 new at 3P s=%0d", s), {7'd0, da}, 8'd1);
            raw = '0;
            step(3 * p + 4);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule